// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Generator

This block drives the four switches of a full-bridge converter that runs at a fixed switching frequency. The output voltage is set only by the phase offset between the two bridge arms. A digital up-counting sawtooth runs from zero to a programmable period value and then wraps. The carrier is compared with two thresholds, one for each arm. Each time a comparator output rises, a divide-by-two flip-flop for that arm toggles. As a result, each arm gets a square wave with 50% duty cycle, and its period is two carrier periods. The switching frequency, for example 100 kHz, is set by the clock rate and the period value.

Arm 0 is the leading arm. It drives S1 as its upper switch and S2 as its lower switch. Arm 1 is the lagging arm. It drives S4 and the complementary S3. A per-arm state machine turns the divide-by-two output into two complementary gates. A programmable dead time is inserted at every changeover, and both switches of the arm are held off during it. The state machine has four states:

- ARM_IDLE: the reset state, with both gates off. It always moves to ARM_DEAD on the next cycle.
- ARM_HIGH: the upper gate is on. When the command falls, it moves to ARM_DEAD if the dead time is non-zero. Otherwise it goes straight to ARM_LOW.
- ARM_LOW: the lower gate is on. When the command rises, it moves to ARM_DEAD if the dead time is non-zero. Otherwise it goes straight to ARM_HIGH.
- ARM_DEAD: both gates are off. After the programmed number of cycles it moves to ARM_HIGH or ARM_LOW, whichever matches the command.

The period, both thresholds and the dead time are captured only in the wrap cycle of the carrier. This means a control loop may rewrite them at any time without distorting the period in progress.

Top module: `psfb_gate_gen`

## Requirements
- R1: While rst_n is low, all four gate outputs are low.
- R2: The carrier counts 0,1,…,P, where P is the captured period value, and then returns to 0. Every gate output therefore repeats every 2·(P+1) clock cycles.
- R3: Each arm's divide-by-two flip-flop toggles exactly once per carrier period, when the carrier first exceeds that arm's threshold. Both flip-flops start at 0 after reset. Thresholds must be below P.
- R4: The rising edge of S4 follows the rising edge of S1 by (thr_lag − thr_lead) mod 2·(P+1) cycles. S1/S2 form the leading arm.
- R5: When both thresholds are equal, S1 equals S4 and S2 equals S3 on every cycle.
- R6: Within an arm the two gates are never on together. S2 is the complement of S1, and S3 the complement of S4, outside dead intervals.
- R7: When one gate of an arm turns off, the other gate of that arm turns on exactly D cycles later, where D is the captured dead time. With D = 0 the handover happens on the same clock edge.
- R8: Every gate stays on for exactly (P+1) − D consecutive cycles per switching period (D ≤ P/2).
- R9: Period, thresholds and dead time are sampled only in the cycle where the carrier equals P. A threshold written mid-period changes nothing until the next carrier period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | CNT_W | Carrier top value P |
| thr_lead_i | input | CNT_W | Threshold for the leading arm (S1/S2) |
| thr_lag_i | input | CNT_W | Threshold for the lagging arm (S3/S4) |
| dead_i | input | DT_W | Dead time D in clock cycles |
| gate_s1_o | output | 1 | Leading arm, upper switch |
| gate_s2_o | output | 1 | Leading arm, lower switch |
| gate_s3_o | output | 1 | Lagging arm, lower switch |
| gate_s4_o | output | 1 | Lagging arm, upper switch |

## Verification
The assertions check several properties on every cycle: no arm ever has both gates on, all gates are low in reset, the opposite gate stays off in the cycle after a changeover when the dead time is non-zero, and the captured settings hold steady except at a carrier wrap. Other properties can only be shown by the bench's scenarios, which measure edge timings across whole switching periods. These are the exact switching period, the on-time, the dead-time gap, the phase lag between the arms (including the wrapped case where the lag threshold is smaller), equality of the arms at equal thresholds, and deferral of a mid-period threshold write.

// File: rtl/psfb_pkg.sv
package psfb_pkg;
    localparam int NUM_ARMS = 2;

    typedef enum logic [1:0] {
        ARM_IDLE = 2'd0,
        ARM_HIGH = 2'd1,
        ARM_LOW  = 2'd2,
        ARM_DEAD = 2'd3
    } arm_state_t;
endpackage

// File: rtl/psfb_carrier.sv
// Sawtooth carrier with settings captured at the wrap.
module psfb_carrier
    import psfb_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DT_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [CNT_W-1:0]               period_i,
    input  logic [NUM_ARMS-1:0][CNT_W-1:0] thr_i,
    input  logic [DT_W-1:0]                dead_i,
    output logic [CNT_W-1:0]               cnt_o,
    output logic [CNT_W-1:0]               period_o,
    output logic [NUM_ARMS-1:0][CNT_W-1:0] thr_o,
    output logic [DT_W-1:0]                dead_o
);
    logic wrap;

    assign wrap = (cnt_o == period_o);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o    <= '0;
            period_o <= '0;
            thr_o    <= '0;
            dead_o   <= '0;
        end else if (wrap) begin
            cnt_o    <= '0;
            period_o <= period_i;
            thr_o    <= thr_i;
            dead_o   <= dead_i;
        end else begin
            cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/psfb_edge_toggle.sv
// Comparator, rising-edge detect and divide-by-two flip-flop for one arm.
module psfb_edge_toggle #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             tog_o
);
    logic cmp_now;
    logic cmp_q;

    assign cmp_now = (cnt_i > thr_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= 1'b0;
            tog_o <= 1'b0;
        end else begin
            cmp_q <= cmp_now;
            if (cmp_now && !cmp_q) begin
                tog_o <= ~tog_o;
            end
        end
    end
endmodule

// File: rtl/psfb_arm_fsm.sv
// Complementary gate pair with dead-time insertion.
module psfb_arm_fsm
    import psfb_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_i,
    input  logic [DT_W-1:0] dead_i,
    output logic            hi_o,
    output logic            lo_o
);
    arm_state_t      state, state_nx;
    logic [DT_W-1:0] dt_cnt;
    logic [DT_W:0]   dt_next;
    logic            dead_zero;

    assign dt_next   = {1'b0, dt_cnt} + {{DT_W{1'b0}}, 1'b1};
    assign dead_zero = (dead_i == '0);

    always_comb begin
        state_nx = state;
        unique case (state)
            ARM_IDLE: state_nx = ARM_DEAD;
            ARM_HIGH: if (!cmd_i) state_nx = dead_zero ? ARM_LOW : ARM_DEAD;
            ARM_LOW:  if (cmd_i)  state_nx = dead_zero ? ARM_HIGH : ARM_DEAD;
            ARM_DEAD: if (dt_next >= {1'b0, dead_i})
                          state_nx = cmd_i ? ARM_HIGH : ARM_LOW;
            default:  state_nx = ARM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ARM_IDLE;
            dt_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state != ARM_DEAD) begin
                dt_cnt <= '0;
            end else begin
                dt_cnt <= dt_next[DT_W-1:0];
            end
        end
    end

    always_comb begin
        hi_o = 1'b0;
        lo_o = 1'b0;
        unique case (state)
            ARM_HIGH: hi_o = 1'b1;
            ARM_LOW:  lo_o = 1'b1;
            default: begin
                hi_o = 1'b0;
                lo_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/psfb_gate_gen.sv
// Top: carrier, two edge toggles, two arm state machines.
module psfb_gate_gen
    import psfb_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] thr_lead_i,
    input  logic [CNT_W-1:0] thr_lag_i,
    input  logic [DT_W-1:0]  dead_i,
    output logic             gate_s1_o,
    output logic             gate_s2_o,
    output logic             gate_s3_o,
    output logic             gate_s4_o
);
    logic [CNT_W-1:0]               carrier_cnt;
    logic [CNT_W-1:0]               period_q;
    logic [NUM_ARMS-1:0][CNT_W-1:0] thr_in;
    logic [NUM_ARMS-1:0][CNT_W-1:0] thr_q;
    logic [DT_W-1:0]                dead_q;
    logic [NUM_ARMS-1:0]            arm_cmd;
    logic [NUM_ARMS-1:0]            arm_hi;
    logic [NUM_ARMS-1:0]            arm_lo;

    assign thr_in[0] = thr_lead_i;
    assign thr_in[1] = thr_lag_i;

    psfb_carrier #(.CNT_W(CNT_W), .DT_W(DT_W)) u_carrier (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (period_i),
        .thr_i    (thr_in),
        .dead_i   (dead_i),
        .cnt_o    (carrier_cnt),
        .period_o (period_q),
        .thr_o    (thr_q),
        .dead_o   (dead_q)
    );

    for (genvar g = 0; g < NUM_ARMS; g++) begin : g_arm
        psfb_edge_toggle #(.CNT_W(CNT_W)) u_tog (
            .clk   (clk),
            .rst_n (rst_n),
            .cnt_i (carrier_cnt),
            .thr_i (thr_q[g]),
            .tog_o (arm_cmd[g])
        );

        psfb_arm_fsm #(.DT_W(DT_W)) u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .cmd_i  (arm_cmd[g]),
            .dead_i (dead_q),
            .hi_o   (arm_hi[g]),
            .lo_o   (arm_lo[g])
        );
    end

    assign gate_s1_o = arm_hi[0];
    assign gate_s2_o = arm_lo[0];
    assign gate_s4_o = arm_hi[1];
    assign gate_s3_o = arm_lo[1];
endmodule

// File: rtl/psfb_gate_checker.sv
module psfb_gate_checker #(
    parameter int CNT_W = 16,
    parameter int DT_W  = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   s1,
    input logic                   s2,
    input logic                   s3,
    input logic                   s4,
    input logic [CNT_W-1:0]       cnt,
    input logic [CNT_W-1:0]       period_q,
    input logic [1:0][CNT_W-1:0]  thr_q,
    input logic [DT_W-1:0]        dead_q
);
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_low_R1: assert (!s1 && !s2 && !s3 && !s4)
                else $error("gates active in reset");
        end
    end

    assert_lead_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(s1 && s2));

    assert_lag_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(s3 && s4));

    assert_dead_lead_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((dead_q != '0) && $fell(s2)) |-> !s1);

    assert_dead_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((dead_q != '0) && $fell(s3)) |-> !s4);

    assert_capture_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != period_q) |=> ($stable(thr_q) && $stable(dead_q) && $stable(period_q)));
endmodule

bind psfb_gate_gen psfb_gate_checker #(.CNT_W(CNT_W), .DT_W(DT_W)) u_gate_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s1       (gate_s1_o),
    .s2       (gate_s2_o),
    .s3       (gate_s3_o),
    .s4       (gate_s4_o),
    .cnt      (carrier_cnt),
    .period_q (period_q),
    .thr_q    (thr_q),
    .dead_q   (dead_q)
);

// File: tb/tb_psfb_gate_gen.sv
module tb_psfb_gate_gen;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 16;
    localparam int DT_W  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] period_i = '0;
    logic [CNT_W-1:0] thr_lead_i = '0;
    logic [CNT_W-1:0] thr_lag_i = '0;
    logic [DT_W-1:0]  dead_i = '0;
    logic             s1, s2, s3, s4;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psfb_gate_gen #(.CNT_W(CNT_W), .DT_W(DT_W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_i   (period_i),
        .thr_lead_i (thr_lead_i),
        .thr_lag_i  (thr_lag_i),
        .dead_i     (dead_i),
        .gate_s1_o  (s1),
        .gate_s2_o  (s2),
        .gate_s3_o  (s3),
        .gate_s4_o  (s4)
    );

    function automatic int exp_period(input int p);
        return 2 * (p + 1);
    endfunction

    function automatic int exp_on(input int p, input int d);
        return (p + 1) - d;
    endfunction

    function automatic int exp_lag(input int p, input int a, input int b);
        return (b - a + exp_period(p)) % exp_period(p);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input int p, input int a, input int b, input int d);
        @(negedge clk);
        period_i   = CNT_W'(p);
        thr_lead_i = CNT_W'(a);
        thr_lag_i  = CNT_W'(b);
        dead_i     = DT_W'(d);
        repeat (4 * (p + 1) + 200) @(negedge clk);
    endtask

    // Measures edge timings over a window and checks R2..R8.
    task automatic measure(input int p, input int a, input int b, input int d);
        int t1 = -1, t1b = -1, tf1 = -1, t2r = -1, t4 = -1, tf4 = -1, t3r = -1;
        int overl = 0, neq = 0;
        logic p1, p2, p3, p4;
        @(negedge clk);
        p1 = s1; p2 = s2; p3 = s3; p4 = s4;
        for (int i = 1; i < 8 * (p + 1); i++) begin
            @(negedge clk);
            if (s1 && !p1) begin
                if (t1 < 0) t1 = i;
                else if (t1b < 0) t1b = i;
            end
            if (t1 >= 0 && tf1 < 0 && !s1 && p1) tf1 = i;
            if (tf1 >= 0 && t2r < 0 && s2 && !p2) t2r = i;
            if (t1 >= 0 && t4 < 0 && s4 && !p4) t4 = i;
            if (t4 >= 0 && tf4 < 0 && !s4 && p4) tf4 = i;
            if (tf4 >= 0 && t3r < 0 && s3 && !p3) t3r = i;
            if ((s1 && s2) || (s3 && s4)) overl++;
            if ((s1 != s4) || (s2 != s3)) neq++;
            p1 = s1; p2 = s2; p3 = s3; p4 = s4;
        end
        check("R2 switching period", t1b - t1, exp_period(p));
        check("R3 R4 lag S1->S4", t4 - t1, exp_lag(p, a, b));
        check("R6 arm overlap cycles", overl, 0);
        check("R7 dead S1off->S2on", t2r - tf1, d);
        check("R7 dead S4off->S3on", t3r - tf4, d);
        check("R8 S1 on-time", tf1 - t1, exp_on(p, d));
        check("R8 S4 on-time", tf4 - t4, exp_on(p, d));
        if (a == b) check("R5 equal-threshold mismatch cycles", neq, 0);
    endtask

    task automatic run_case(input int p, input int a, input int b, input int d);
        apply(p, a, b, d);
        measure(p, a, b, d);
    endtask

    // R9: a lag threshold written just after an S1 rise is deferred.
    task automatic mid_period_write();
        int t = 0, t1 = -1, t4 = -1, t1n = -1, t4n = -1;
        logic p1, p4;
        apply(59, 5, 30, 2);
        p1 = s1;
        while (!(s1 && !p1) && t < 400) begin
            p1 = s1; @(negedge clk); t++;
        end
        thr_lag_i = CNT_W'(40);
        t1 = 0; p1 = s1; p4 = s4;
        for (int i = 1; i < 300; i++) begin
            @(negedge clk);
            if (t4 < 0 && s4 && !p4) t4 = i;
            if (t1n < 0 && s1 && !p1) t1n = i;
            if (t1n >= 0 && t4n < 0 && s4 && !p4) t4n = i;
            p1 = s1; p4 = s4;
        end
        check("R9 lag in period of write", t4 - t1, 25);
        check("R9 lag after next wrap", t4n - t1n, 35);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1234));
        period_i = CNT_W'(19); thr_lead_i = CNT_W'(3); thr_lag_i = CNT_W'(9); dead_i = DT_W'(2);
        repeat (5) begin
            @(negedge clk);
            check("R1 gates low in reset", {s1, s2, s3, s4}, 0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corners.
        run_case(19, 3, 9, 2);    // R4 basic lag
        run_case(19, 9, 3, 2);    // R4 wrapped lag
        run_case(31, 7, 7, 3);    // R5 equal thresholds
        run_case(31, 0, 30, 1);   // R3 extreme thresholds
        run_case(15, 4, 10, 0);   // R7 zero dead time
        run_case(23, 12, 12, 0);  // R5 with zero dead time
        mid_period_write();       // R9

        // Constrained random.
        for (int k = 0; k < 10; k++) begin
            int p, a, b, d;
            p = $urandom_range(60, 8);
            a = $urandom_range(p - 1, 0);
            b = $urandom_range(p - 1, 0);
            d = $urandom_range(p / 2, 0);
            run_case(p, a, b, d);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule